// File: doc/BRIEF.md
# Free-Running Timer with Latched High-Word Readout

A memory-mapped operating-system timer whose counter is wider than the 32-bit register bus it sits on. In the default build the count is 64 bits and software reads it in two accesses. A read of the low count word copies the live high word, at that same clock edge, into a separate hold register. A later read of the hold register therefore returns the high word that belongs with the low word already fetched, even if a carry has since moved the live high word. A parameter selects a reduced 32-bit build with one count register and no hold register.

The counter advances by one on each cycle where the `tick` qualifier is high and the timer has been started. A write-one-to-set port starts it and a write-one-to-clear port stops it. A compare register and a mode bit decide what happens when the count equals the compare value on a tick. The counter either restarts from zero or keeps running. In both modes the match raises a sticky flag that drives `irq`. The bus is a plain strobe interface. It is always ready and has no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` with `bus_rvalid` one cycle after the `bus_rd` strobe.

Top module: `ost_timer`

## Requirements
- R1: After reset the timer is stopped, the count words and the hold register read 0, control reads 0 (mode bit 0, flag 0), the compare register reads all ones, and `irq` is 0.
- R2: While started, the count rises by exactly one on each clock edge where `tick` is 1, and it does not change on edges where `tick` is 0.
- R3: A read of the low count word (address 3) loads the hold register with the live high word at the same edge. A read of address 5 returns that copy, not the live high word at address 4. Read data is valid one cycle after the strobe.
- R4: Every later read of address 3 reloads the hold register. A low word from one read can therefore be paired with a high word from a later read.
- R5: Control bit 15 is the mode. With mode 0, a tick while the count equals the compare value (addresses 1 and 2) loads zero. With mode 1, the counter steps past the compare value.
- R6: Control (address 0) bits 15 to 6 are written together and read back. Bits 5 to 1 and 31 to 16 read 0.
- R7: Writing 1 to bit 15 of address 6 starts the timer. Writing 0 there has no effect. Bit 15 of address 6 or 7 reads the running state.
- R8: Writing 1 to bit 15 of address 7 stops the timer, and the count then holds its value.
- R9: Both count words (addresses 3 and 4) are writable. A count write in the same cycle as a tick wins over the increment.
- R10: A compare match sets control bit 0, which drives `irq`. The flag stays set until a control write with bit 0 equal to 1 clears it.
- R11: With `WIDE_CNT` = 0 the count is 32 bits at address 4 and wraps from all ones to zero. Addresses 3 and 5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count qualifier, one increment per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High one cycle after a read strobe |
| irq | output | 1 | Level of the sticky compare-match flag |

## Verification
A wrong hold register shows up on the very next read of address 5: a high word that does not match the low word captured before a forced carry. A wrong count, whether from a missed tick, a lost write priority or a broken compare restart, differs from the tick-count arithmetic at the first read after the fault. A compare that fires one tick early or late shows up during the period sweep, both in the count read back and in `irq` at the exact tick where the restart is due. A faulty start/stop latch shows up as a count that moves, or fails to move, across a known burst of ticks.

// File: rtl/ost_pkg.sv
package ost_pkg;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPL = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPH = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNTH = 3'd4;
  localparam logic [ADDR_W-1:0] A_HOLD = 3'd5;
  localparam logic [ADDR_W-1:0] A_RUNS = 3'd6;
  localparam logic [ADDR_W-1:0] A_RUNC = 3'd7;
  localparam int RUN_BIT = 15;
  localparam int MODE_LSB = 6;
  localparam int MODE_W = 10;
endpackage

// File: rtl/ost_gate.sv
module ost_gate #(
  parameter int BIT = 15,
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_wr,
  input  logic         clr_wr,
  input  logic [W-1:0] wdata,
  output logic         run
);
  logic set_hit, clr_hit;
  assign set_hit = set_wr & wdata[BIT];
  assign clr_hit = clr_wr & wdata[BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) run <= 1'b0;
    else if (set_hit) run <= 1'b1;
    else if (clr_hit) run <= 1'b0;
  end

  // R7
  run_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_hit && !clr_hit |=> $stable(run));
  // R8
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && !set_hit |=> !run);
endmodule

// File: rtl/ost_hold.sv
module ost_hold #(
  parameter bit PRESENT = 1'b1,
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] hi_in,
  output logic [W-1:0] held
);
  generate
    if (PRESENT) begin : g_buf
      logic [W-1:0] buf_q;
      always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else if (load) buf_q <= hi_in;
      end
      assign held = buf_q;

      // R3
      hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> buf_q == $past(hi_in));
      // R4
      hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(buf_q));
    end else begin : g_none
      assign held = '0;
    end
  endgenerate
endmodule

// File: rtl/ost_count.sv
module ost_count #(
  parameter bit WIDE = 1'b1,
  parameter int CNT_W = 64,
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             free_run,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [W-1:0]     wdata,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2*W-1:0]   ext;
  logic             wr_any, step;

  assign wr_any = (wr_lo & WIDE) | wr_hi;
  assign step   = run & tick & ~wr_any;
  assign hit    = step & (cnt_q == cmp);

  always_comb begin
    ext = (2*W)'(cnt_q);
    if (WIDE) begin
      if (wr_lo) ext[W-1:0] = wdata;
      if (wr_hi) ext[2*W-1:W] = wdata;
    end else if (wr_hi) begin
      ext[W-1:0] = wdata;
    end
    if (wr_any) cnt_d = ext[CNT_W-1:0];
    else if (step && hit && !free_run) cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
    else cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end
  assign cnt = cnt_q;

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_any |=> $stable(cnt_q));
  // R5
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !free_run |=> cnt_q == '0);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !hit |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/ost_timer.sv
module ost_timer #(
  parameter bit WIDE_CNT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        irq
);
  import ost_pkg::*;
  localparam int CNT_W = WIDE_CNT ? 2*BUS_W : BUS_W;

  logic [CNT_W-1:0]  cmp_q, cnt;
  logic [2*BUS_W-1:0] cmp_x, cnt_x;
  logic [MODE_W-1:0] mode_q;
  logic              flag_q, hit, run, hold_load, flag_clr;
  logic [BUS_W-1:0]  held, rd_mux;

  assign hold_load = bus_rd & (bus_addr == A_CNTL) & WIDE_CNT;
  assign flag_clr  = bus_wr & (bus_addr == A_CTRL) & bus_wdata[0];

  ost_gate #(.BIT(RUN_BIT), .W(BUS_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .set_wr(bus_wr & (bus_addr == A_RUNS)),
    .clr_wr(bus_wr & (bus_addr == A_RUNC)),
    .wdata(bus_wdata), .run(run));

  ost_count #(.WIDE(WIDE_CNT), .CNT_W(CNT_W), .W(BUS_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .free_run(mode_q[MODE_W-1]),
    .wr_lo(bus_wr & (bus_addr == A_CNTL)),
    .wr_hi(bus_wr & (bus_addr == A_CNTH)),
    .wdata(bus_wdata), .cmp(cmp_q), .cnt(cnt), .hit(hit));

  ost_hold #(.PRESENT(WIDE_CNT), .W(BUS_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(hold_load),
    .hi_in(cnt_x[2*BUS_W-1:BUS_W]), .held(held));

  assign cnt_x = (2*BUS_W)'(cnt);
  assign cmp_x = (2*BUS_W)'(cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      mode_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CMPL) cmp_q[BUS_W-1:0] <= bus_wdata;
      if (bus_wr && bus_addr == A_CMPH && WIDE_CNT)
        cmp_q <= CNT_W'({bus_wdata, cmp_x[BUS_W-1:0]});
      if (bus_wr && bus_addr == A_CTRL) mode_q <= bus_wdata[MODE_LSB +: MODE_W];
      if (hit) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: rd_mux = {16'b0, mode_q, 5'b0, flag_q};
      A_CMPL: rd_mux = cmp_x[BUS_W-1:0];
      A_CMPH: rd_mux = cmp_x[2*BUS_W-1:BUS_W];
      A_CNTL: rd_mux = WIDE_CNT ? cnt_x[BUS_W-1:0] : '0;
      A_CNTH: rd_mux = WIDE_CNT ? cnt_x[2*BUS_W-1:BUS_W] : cnt_x[BUS_W-1:0];
      A_HOLD: rd_mux = held;
      default: rd_mux[RUN_BIT] = run;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign irq = flag_q;

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !flag_clr |=> flag_q);
  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq);
  // R3
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
endmodule

// File: tb/tb_ost_timer.sv
module tb_ost_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_w, rdata_n;
  logic rvalid_w, rvalid_n, irq_w, irq_n;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] v, lo_a;

  always #10 clk = ~clk;

  ost_timer #(.WIDE_CNT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_w),
    .bus_rvalid(rvalid_w), .irq(irq_w));

  ost_timer #(.WIDE_CNT(1'b0)) dut_n (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_n),
    .bus_rvalid(rvalid_n), .irq(irq_n));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] dw, output logic [31:0] dn);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    dw = rdata_w; dn = rdata_n;
    chk("R3 rvalid", {31'b0, rvalid_w}, 32'd1);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] dn;
    do_reset();
    // R1 reset state
    rd(3'd3, v, dn); chk("R1 cnt_lo", v, 32'h0);
    rd(3'd4, v, dn); chk("R1 cnt_hi", v, 32'h0);
    rd(3'd5, v, dn); chk("R1 hold", v, 32'h0);
    rd(3'd0, v, dn); chk("R1 ctrl", v, 32'h0);
    rd(3'd1, v, dn); chk("R1 cmp_lo", v, 32'hFFFF_FFFF);
    rd(3'd6, v, dn); chk("R1 run", v, 32'h0);
    chk("R1 irq", {31'b0, irq_w}, 32'h0);
    // R7 writing 0 does nothing
    wr(3'd6, 32'h0000_7FFF);
    ticks(3);
    rd(3'd3, v, dn); chk("R7 zero write ignored", v, 32'h0);
    wr(3'd6, 32'h0000_8000);
    rd(3'd7, v, dn); chk("R7 run readback", v, 32'h0000_8000);
    ticks(3);
    rd(3'd3, v, dn); chk("R2 three ticks", v, 32'd3);
    repeat (4) @(negedge clk);
    rd(3'd3, v, dn); chk("R2 idle without tick", v, 32'd3);
    // R6 control group
    wr(3'd0, 32'hFFFF_FFC0);
    rd(3'd0, v, dn); chk("R6 group readback", v, 32'h0000_FFC0);
    wr(3'd0, 32'h0000_8000);
    rd(3'd0, v, dn); chk("R6 mode only", v, 32'h0000_8000);
    // R9 write beats increment
    @(negedge clk);
    tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'd100;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd(3'd3, v, dn); chk("R9 write priority", v, 32'd100);
    // R3 carry between the two halves
    wr(3'd4, 32'd5);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, lo_a, dn); chk("R3 low before carry", lo_a, 32'hFFFF_FFFF);
    ticks(1);
    rd(3'd5, v, dn); chk("R3 hold keeps old high", v, 32'd5);
    rd(3'd4, v, dn); chk("R3 live high moved", v, 32'd6);
    rd(3'd3, v, dn); chk("R9/R2 low wrapped", v, 32'd0);
    // R4 a second reader reloads the hold register
    rd(3'd5, v, dn); chk("R4 reload by later read", v, 32'd6);
    // R8 stop and hold
    wr(3'd7, 32'h0000_8000);
    ticks(4);
    rd(3'd3, v, dn); chk("R8 held low", v, 32'd0);
    rd(3'd4, v, dn); chk("R8 held high", v, 32'd6);
    rd(3'd6, v, dn); chk("R8 run cleared", v, 32'h0);
    wr(3'd6, 32'h0000_8000);
    // R5 / R10 sweep over compare periods
    for (int c = 1; c <= 6; c++) begin
      wr(3'd0, 32'h0000_0001);
      wr(3'd2, 32'h0);
      wr(3'd1, c);
      wr(3'd4, 32'h0);
      wr(3'd3, 32'h0);
      chk("R10 flag cleared", {31'b0, irq_w}, 32'h0);
      ticks(c);
      rd(3'd3, v, dn); chk("R5 reach compare", v, c);
      chk("R10 no early flag", {31'b0, irq_w}, 32'h0);
      ticks(1);
      rd(3'd3, v, dn); chk("R5 restart at zero", v, 32'h0);
      rd(3'd0, v, dn); chk("R10 flag set", v, 32'h0000_0001);
      chk("R10 irq", {31'b0, irq_w}, 32'h1);
      wr(3'd0, 32'h0000_8001);
      wr(3'd3, 32'h0);
      ticks(c + 2);
      rd(3'd3, v, dn); chk("R5 free run passes compare", v, c + 2);
      chk("R10 flag in free run", {31'b0, irq_w}, 32'h1);
      wr(3'd0, 32'h0000_8000);
      chk("R10 bit0 zero keeps flag", {31'b0, irq_w}, 32'h1);
    end
    wr(3'd0, 32'h0000_8001);
    chk("R10 clear", {31'b0, irq_w}, 32'h0);
    // R11 narrow build
    do_reset();
    wr(3'd6, 32'h0000_8000);
    ticks(5);
    rd(3'd4, v, dn); chk("R11 narrow count", dn, 32'd5);
    rd(3'd3, v, dn); chk("R11 no low word", dn, 32'h0);
    rd(3'd5, v, dn); chk("R11 no hold", dn, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);
    ticks(1);
    rd(3'd4, v, dn); chk("R11 wrap", dn, 32'h0);
    chk("R11 wrap irq", {31'b0, irq_n}, 32'h1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule